// File: doc/BRIEF.md
# Multi-channel compare-match timer cluster

The cluster gathers up to fifteen compare-match timer channels behind one word-addressed register space. A global run word holds one run bit per channel, at the channel's physical index. A separate clock-enable word gates each channel's count clock. Software starts or stops a single channel with a read-modify-write of the run word. That write leaves every other channel's run bit, and so its count, untouched.

Each channel has three registers: a control word, an up-counter and a compare value. When an advancing counter equals its compare value, the channel latches a match flag. Depending on its control word, the counter then either returns to zero or keeps counting and wraps at its maximum. Every channel drives its own interrupt line, indexed by physical channel number. A presence mask picks which physical channels are built. An absent channel reads as zero everywhere, ignores writes and never raises its interrupt.

Top module: `tmr_cluster`

## Requirements
- R1: After reset, the run word and the clock-enable word read 0, every counter reads 0, every compare value reads all ones and every interrupt line is low.
- R2: The run word is at byte offset 0x000, with bit n belonging to channel n; it reads back what was written, restricted to present channels.
- R3: A run-word write takes effect two clocks after the write edge. For a write at edge k, a started counter first advances at edge k+2, and a stopped counter still advances at edge k+1 but not at edge k+2 or later.
- R4: Channel n's block starts at byte offset 0x10 + 0x10*n: control at +0x0, counter at +0x4, compare at +0x8. In the control word, bit 0 is the interrupt enable, bit 1 selects clear-on-match and bit 7 is the match flag. Writing bit 7 as 0 clears the flag, and writing it as 1 leaves it unchanged.
- R5: At an advancing edge where the counter equals the compare value, the match flag sets. With clear-on-match the counter goes to 0; without it the counter increments, wrapping from all ones to 0.
- R6: irq_o[n] is high exactly while channel n's match flag and interrupt enable are both set.
- R7: The clock-enable word is at byte offset 0x1000, with bit n belonging to channel n. A counter advances only while both its delayed run bit and its clock-enable bit are set.
- R8: For an absent channel, reads of its block return 0 and writes to it have no effect. Its run and clock-enable bits read 0 and its interrupt stays low.
- R9: Changing one channel's run bit does not disturb the counting of any other running channel.
- R10: A write to a channel's counter register loads that value into the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and counting |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read (registered, data one clock later) |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the clock after the read strobe |
| irq_o | output | NCH | Per-channel interrupt lines |

## Verification
The bench builds the cluster with eight physical channels and the sparse presence mask 0x65, so channels 0, 2, 5 and 6 exist. Channel 1's block and the unpopulated run and clock-enable bits then show the absent-channel behaviour at the bus. With 32-bit counters, a counter preloaded to all ones reaches the wrap. Reading a counter back to back, with one read per clock right after a run-word write, pins down the two-clock start latency. Running two channels at once, and stopping one of them, shows the effect of a run-word change on the other.

// File: rtl/tmr_pkg.sv
// Shared constants for the timer cluster: register offsets inside the
// global space, register selectors inside a channel block and control bits.
package tmr_pkg;

    localparam int unsigned RUN_OFS   = 32'h000;
    localparam int unsigned CLKEN_OFS = 32'h1000;

    typedef enum logic [1:0] {
        CH_CTRL  = 2'd0,
        CH_COUNT = 2'd1,
        CH_CMP   = 2'd2,
        CH_NONE  = 2'd3
    } ch_reg_e;

    localparam int unsigned CTRL_IE_BIT   = 0;
    localparam int unsigned CTRL_CLR_BIT  = 1;
    localparam int unsigned CTRL_FLAG_BIT = 7;

endpackage

// File: rtl/tmr_run_ctl.sv
// Global run word and clock-enable word of the cluster.
// Run bits pass through one extra register, so a write reaches the counters
// two clocks after the write edge. Clock-enable bits act at once.
// Assumes: bits of absent channels (PRES = 0) are never stored.
module tmr_run_ctl #(
    parameter int unsigned NCH = 8,
    parameter logic [NCH-1:0] PRES = '1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_run_i,
    input  logic           wr_clk_i,
    input  logic [NCH-1:0] wdata_i,
    output logic [NCH-1:0] run_o,
    output logic [NCH-1:0] clken_o,
    output logic [NCH-1:0] adv_o
);
    logic [NCH-1:0] run_q;
    logic [NCH-1:0] run_dly_q;
    logic [NCH-1:0] clken_q;

    // Store run and clock-enable writes, masked to present channels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            clken_q <= '0;
        end else begin
            if (wr_run_i) run_q   <= wdata_i & PRES;
            if (wr_clk_i) clken_q <= wdata_i & PRES;
        end
    end

    // Second stage of the run-bit latency.
    always_ff @(posedge clk) begin
        if (!rst_n) run_dly_q <= '0;
        else        run_dly_q <= run_q;
    end

    assign run_o   = run_q;
    assign clken_o = clken_q;
    assign adv_o   = run_dly_q & clken_q;

    AST_RUN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_q | clken_q) & ~PRES) == '0);                          // R8
    AST_START_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        wr_run_i |-> ##2 (run_dly_q == ($past(wdata_i, 2) & PRES))); // R3

endmodule

// File: rtl/tmr_channel.sv
// One compare-match channel: up-counter, compare value and control word.
// The counter advances on edges where adv_i is high. A match sets the flag
// and either clears the counter or lets it run on and wrap.
// Assumes: CNT_W >= 8, so the control bits fit inside the write data.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  ch_reg_e          rsel_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             adv_i,
    output logic [CNT_W-1:0] rdata_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    logic             ie_q;
    logic             clr_q;
    logic             flag_q;
    logic             hit;
    logic             cnt_wr;
    logic             ctrl_wr;
    logic             cmp_wr;

    assign hit     = adv_i && (cnt_q == cmp_q);
    assign cnt_wr  = wr_en_i && (rsel_i == CH_COUNT);
    assign ctrl_wr = wr_en_i && (rsel_i == CH_CTRL);
    assign cmp_wr  = wr_en_i && (rsel_i == CH_CMP);

    // Counter: a bus load wins, otherwise advance, clearing on match if asked.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (cnt_wr)  cnt_q <= wdata_i;
        else if (adv_i)   cnt_q <= (hit && clr_q) ? '0 : cnt_q + 1'b1;
    end

    // Compare value and control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
            ie_q  <= 1'b0;
            clr_q <= 1'b0;
        end else begin
            if (cmp_wr) cmp_q <= wdata_i;
            if (ctrl_wr) begin
                ie_q  <= wdata_i[CTRL_IE_BIT];
                clr_q <= wdata_i[CTRL_CLR_BIT];
            end
        end
    end

    // Match flag: set by a match, cleared by writing its bit as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= hit || (flag_q && !(ctrl_wr && !wdata_i[CTRL_FLAG_BIT]));
    end

    // Read selection for the register named by rsel_i.
    always_comb begin
        rdata_o = '0;
        case (rsel_i)
            CH_CTRL: begin
                rdata_o[CTRL_IE_BIT]   = ie_q;
                rdata_o[CTRL_CLR_BIT]  = clr_q;
                rdata_o[CTRL_FLAG_BIT] = flag_q;
            end
            CH_COUNT: rdata_o = cnt_q;
            CH_CMP:   rdata_o = cmp_q;
            default:  rdata_o = '0;
        endcase
    end

    assign irq_o = flag_q && ie_q;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !cnt_wr) |=> $stable(cnt_q));                      // R7
    AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && clr_q && !cnt_wr) |=> (cnt_q == '0));                 // R5
    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(adv_i && (cnt_q == cmp_q)));          // R5

endmodule

// File: rtl/tmr_cluster.sv
// Timer cluster top: decodes the byte address to the run word, the
// clock-enable word or a channel block, builds only the channels named in
// PRESENT and returns read data one clock after a read strobe.
// Assumes: NCH <= 15 (channel field is address bits 7:4), ADDR_W >= 13,
// CNT_W <= DATA_W.
module tmr_cluster
    import tmr_pkg::*;
#(
    parameter int unsigned NCH     = 8,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 13,
    parameter logic [NCH-1:0] PRESENT = 8'h3F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    irq_o
);
    localparam int unsigned FLD_W = 4;

    logic             aligned;
    logic             is_run;
    logic             is_clk;
    logic             in_blk;
    logic [FLD_W-1:0] ch_fld;
    ch_reg_e          rsel;
    logic             do_wr;
    logic             rd_req;
    logic             absent_hit;
    logic [NCH-1:0]   run_w;
    logic [NCH-1:0]   clken_w;
    logic [NCH-1:0]   adv_w;
    logic [NCH-1:0]   irq_w;
    logic [DATA_W-1:0] ch_rd [NCH];
    logic [DATA_W-1:0] rd_nxt;

    // Address decode into global words and channel blocks.
    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        is_run  = (bus_addr == ADDR_W'(RUN_OFS));
        is_clk  = (bus_addr == ADDR_W'(CLKEN_OFS));
        ch_fld  = bus_addr[7:4];
        in_blk  = aligned && (bus_addr[ADDR_W-1:8] == '0) && (ch_fld != '0)
                  && (ch_fld <= FLD_W'(NCH));
        rsel    = ch_reg_e'(bus_addr[3:2]);
    end

    assign do_wr  = bus_sel && bus_wr;
    assign rd_req = bus_sel && !bus_wr;

    // Flags a block access aimed at a channel that is not built.
    always_comb begin
        absent_hit = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (in_blk && ch_fld == FLD_W'(i + 1) && !PRESENT[i]) absent_hit = 1'b1;
        end
    end

    tmr_run_ctl #(
        .NCH  (NCH),
        .PRES (PRESENT)
    ) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_run_i (do_wr && is_run),
        .wr_clk_i (do_wr && is_clk),
        .wdata_i  (bus_wdata[NCH-1:0]),
        .run_o    (run_w),
        .clken_o  (clken_w),
        .adv_o    (adv_w)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        if (PRESENT[g]) begin : g_on
            logic [CNT_W-1:0] rd_c;
            tmr_channel #(
                .CNT_W (CNT_W)
            ) u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en_i (do_wr && in_blk && (ch_fld == FLD_W'(g + 1))),
                .rsel_i  (rsel),
                .wdata_i (bus_wdata[CNT_W-1:0]),
                .adv_i   (adv_w[g]),
                .rdata_o (rd_c),
                .irq_o   (irq_w[g])
            );
            assign ch_rd[g] = DATA_W'(rd_c);
        end else begin : g_off
            assign ch_rd[g] = '0;
            assign irq_w[g] = 1'b0;
        end
    end

    // Read data select for the addressed register.
    always_comb begin
        rd_nxt = '0;
        if (is_run) rd_nxt = DATA_W'(run_w);
        if (is_clk) rd_nxt = DATA_W'(clken_w);
        for (int i = 0; i < NCH; i++) begin
            if (in_blk && ch_fld == FLD_W'(i + 1)) rd_nxt = ch_rd[i];
        end
    end

    // Registered read port, updated on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_req) bus_rdata <= rd_nxt;
    end

    assign irq_o = irq_w;

    AST_ABSENT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && absent_hit) |=> (bus_rdata == '0));                // R8

endmodule

// File: tb/sim_tmr_cluster.sv
`timescale 1ns/1ps
module sim_tmr_cluster;
    localparam int unsigned NCH = 8;
    localparam logic [NCH-1:0] PRES = 8'h65;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq_o;

    int n_chk = 0;
    int n_fail = 0;
    logic rd_d = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    tmr_cluster #(.NCH(NCH), .CNT_W(32), .DATA_W(32), .ADDR_W(13), .PRESENT(PRES)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // Remember which edges captured a read.
    always @(posedge clk) rd_d <= bus_sel && !bus_wr;

    // Monitor: compare each captured read against the queued expectation.
    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (bus_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata actual=%h expected=%h", t, bus_rdata, e);
            end
        end
    end

    // Driver tasks start and end at a falling edge.
    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, input logic [31:0] e, input string t);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(input logic [7:0] e, input string t);
        n_chk++;
        if (irq_o !== e) begin
            n_fail++;
            $display("FAIL %s: irq actual=%h expected=%h", t, irq_o, e);
        end
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk); rst_n = 1'b1;
                // R1 reset state
                chk_irq(8'h00, "R1");
                rd(13'h000, 32'h0, "R1 run");
                rd(13'h1000, 32'h0, "R1 clken");
                rd(13'h018, 32'hFFFF_FFFF, "R1 cmp");
                rd(13'h014, 32'h0, "R1 count");
                // R10 counter load
                wr(13'h014, 32'h0000_1234);
                rd(13'h014, 32'h0000_1234, "R10");
                wr(13'h014, 32'h0);
                // R8 absent channel 1 and masked words
                wr(13'h024, 32'd123);
                rd(13'h024, 32'h0, "R8 absent block");
                wr(13'h1000, 32'hFF);
                rd(13'h1000, 32'h65, "R8 clken mask");
                wr(13'h000, 32'h02);
                rd(13'h000, 32'h0, "R8 run mask");
                chk_irq(8'h00, "R8 irq");
                // R7 clock gate off for channel 6
                wr(13'h1000, 32'h25);
                wr(13'h000, 32'h40);
                idle(3);
                wr(13'h000, 32'h0);
                idle(2);
                rd(13'h074, 32'h0, "R7 gated");
                wr(13'h1000, 32'h65);
                // R3/R2 start latency on channel 0
                wr(13'h000, 32'h01);
                rd(13'h014, 32'd0, "R3 k+1");
                rd(13'h014, 32'd0, "R3 k+2");
                rd(13'h014, 32'd1, "R3 k+3");
                rd(13'h014, 32'd2, "R3 k+4");
                rd(13'h000, 32'h01, "R2 readback");
                wr(13'h000, 32'h0);
                idle(1);
                rd(13'h014, 32'd6, "R3 stop");
                rd(13'h014, 32'd6, "R3 stopped");
                // R9 stop channel 5 while channel 0 runs
                wr(13'h014, 32'h0);
                wr(13'h000, 32'h21);
                idle(3);
                wr(13'h000, 32'h01);
                idle(2);
                wr(13'h000, 32'h0);
                idle(2);
                rd(13'h014, 32'd7, "R9 ch0");
                rd(13'h064, 32'd4, "R9 ch5");
                // R5/R4/R6 clear-on-match on channel 2
                wr(13'h038, 32'd3);
                wr(13'h030, 32'h03);
                wr(13'h000, 32'h04);
                idle(4);
                wr(13'h000, 32'h0);
                idle(2);
                rd(13'h034, 32'd1, "R5 clear");
                rd(13'h030, 32'h83, "R4 flag");
                chk_irq(8'h04, "R6 raised");
                wr(13'h030, 32'h03);
                rd(13'h030, 32'h03, "R4 flag clear");
                chk_irq(8'h00, "R6 cleared");
                // R5/R6 free run, interrupt disabled
                wr(13'h030, 32'h00);
                wr(13'h038, 32'd5);
                wr(13'h034, 32'd4);
                wr(13'h000, 32'h04);
                idle(1);
                wr(13'h000, 32'h0);
                idle(2);
                rd(13'h034, 32'd6, "R5 run-on");
                rd(13'h030, 32'h80, "R4 flag no ie");
                chk_irq(8'h00, "R6 gated");
                wr(13'h030, 32'h81);
                rd(13'h030, 32'h81, "R4 write1 keeps");
                chk_irq(8'h04, "R6 enabled");
                // R5 wrap at all ones
                wr(13'h030, 32'h01);
                wr(13'h034, 32'hFFFF_FFFF);
                wr(13'h000, 32'h04);
                idle(1);
                wr(13'h000, 32'h0);
                idle(2);
                rd(13'h034, 32'd1, "R5 wrap");
                idle(2);
            end
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual=running expected=finished");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule